// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a watchdog for a small microcontroller-style system. It counts ticks from one of two sources and raises a one-cycle reset request if software does not service it in time. The two sources are a slow oscillator and the bus clock. Each source reaches the block as a single-cycle enable on the system clock, so the whole block runs in one clock domain. Software services the watchdog by writing to a service strobe. Any such write restarts the count from zero.

Software sets the block up through a configuration register that can be written once. The register holds an enable bit, a source select bit and a three-bit timeout code. The first write after reset is kept and every later write is dropped. This holds even when the first write repeats the reset defaults, so a lost program cannot switch the watchdog off.

Counting pauses while the debug flag is high. Counting is cleared and held while the stop flag is high. After stop ends, the first three ticks of the selected source are swallowed, and only then does counting restart.

Top module: `wdog_top`

## Requirements
- R1: After reset the block is enabled, selects the slow oscillator, and uses timeout code 7. A reset request therefore follows 2^LFO_EXP slow ticks with no service.
- R2: The configuration input is packed as follows: bit 4 is enable, bit 3 is source select (1 = bus ticks, 0 = slow ticks), and bits 2:0 are the timeout code. Only the first configuration write after reset takes effect; all later writes are ignored, including when the first write equals the defaults.
- R3: With bus ticks selected, code c from 0 to 6 gives a timeout of 2^(BUS_EXP+c) bus ticks. Code 7 gives the same timeout as code 6.
- R4: With slow ticks selected, every code gives a timeout of 2^LFO_EXP slow ticks.
- R5: A service write clears the count. When a service write and a tick land in the same cycle, the service wins and no request is produced.
- R6: While the debug flag is high, ticks do not advance the count, and the count resumes from where it stopped.
- R7: While the stop flag is high, the count is zero and no request is produced.
- R8: After the stop flag falls, the first 3 ticks of the selected source are ignored. Ticks of the other source do not use up those 3.
- R9: When the enable bit is 0, no reset request is ever produced.
- R10: The reset request is high for exactly one cycle, in the cycle after the tick that completes the timeout. The count then restarts, so the next request needs a full timeout.
- R11: Ticks of the source that is not selected have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lfo_tick | input | 1 | Single-cycle enable marking one slow oscillator cycle |
| bus_tick | input | 1 | Single-cycle enable marking one bus clock cycle |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration data: {enable, source select, code[2:0]} |
| svc_wr | input | 1 | Service write strobe; clears the count |
| dbg_mode | input | 1 | Debug flag; pauses counting |
| stop_mode | input | 1 | Stop flag; clears and holds the count |
| wdog_rst | output | 1 | One-cycle reset request |

## Verification
The count is internal, so an error in it shows only in when the request arrives. The bench measures how many ticks pass between a chosen starting point and the request, and compares that number with the timeout the configuration implies. An early request, a late request, or no request within twice the longest timeout exposes the fault. A lock that fails or a restart delay of the wrong length shows up as a wrong tick count on the first measurement after the stimulus. The bench sweeps every source and code pair from a fresh reset to check this.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef struct packed {
    logic       en;
    logic       bus_sel;
    logic [2:0] code;
  } wdog_cfg_t;

  localparam wdog_cfg_t WDOG_CFG_RESET = '{en: 1'b1, bus_sel: 1'b0, code: 3'd7};

  // Log2 of the overflow count for a configuration.
  function automatic int ovf_log2(input int bus_exp, input int lfo_exp,
                                  input logic bus_sel, input logic [2:0] code);
    int step;
    step = (code == 3'd7) ? 6 : int'(code);
    return bus_sel ? (bus_exp + step) : lfo_exp;
  endfunction

endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_wr,
  input  wdog_cfg_t cfg_wdata,
  output wdog_cfg_t cfg_q
);

  logic locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= WDOG_CFG_RESET;
      locked <= 1'b0;
    end else if (cfg_wr && !locked) begin
      cfg_q  <= cfg_wdata;
      locked <= 1'b1;
    end
  end

  p_lock_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(cfg_q) && locked));

endmodule

// File: rtl/wdog_tick_gate.sv
module wdog_tick_gate #(
  parameter int RESTART_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lfo_tick,
  input  logic bus_tick,
  input  logic bus_sel,
  input  logic stop_mode,
  output logic tick_sel,
  output logic restart_hold
);

  localparam int DLY_W = $clog2(RESTART_TICKS + 1);

  logic [DLY_W-1:0] dly;

  assign tick_sel     = bus_sel ? bus_tick : lfo_tick;
  assign restart_hold = (dly != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dly <= '0;
    else if (stop_mode)
      dly <= DLY_W'(RESTART_TICKS);
    else if (restart_hold && tick_sel)
      dly <= dly - 1'b1;
  end

  p_exit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_mode) |-> restart_hold);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             hold,
  input  logic             dbg_mode,
  input  logic             stop_mode,
  input  logic             svc_wr,
  input  logic [CNT_W-1:0] last_val,
  output logic             wdog_rst
);

  logic [CNT_W-1:0] cnt;
  logic             cnt_advance;
  logic             ovf_hit;

  assign cnt_advance = tick && en && !dbg_mode && !hold && !stop_mode && !svc_wr;
  assign ovf_hit     = cnt_advance && (cnt == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      wdog_rst <= 1'b0;
    end else begin
      wdog_rst <= ovf_hit;
      if (!en || stop_mode || svc_wr || ovf_hit)
        cnt <= '0;
      else if (cnt_advance)
        cnt <= cnt + 1'b1;
    end
  end

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |=> !wdog_rst);

  p_svc_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    svc_wr |=> (cnt == '0 && !wdog_rst));

  p_dbg_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && en && !svc_wr && !stop_mode) |=> $stable(cnt));

  p_stop_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |=> (cnt == '0 && !wdog_rst));

  p_restart_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && en && !svc_wr && !stop_mode) |=> $stable(cnt));

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !wdog_rst);

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int BUS_EXP       = 13,
  parameter int LFO_EXP       = 11,
  parameter int RESTART_TICKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lfo_tick,
  input  logic       bus_tick,
  input  logic       cfg_wr,
  input  logic [4:0] cfg_wdata,
  input  logic       svc_wr,
  input  logic       dbg_mode,
  input  logic       stop_mode,
  output logic       wdog_rst
);

  localparam int MAX_EXP = (BUS_EXP + 6 > LFO_EXP) ? (BUS_EXP + 6) : LFO_EXP;
  localparam int CNT_W   = MAX_EXP;

  wdog_cfg_t        cfg_q;
  logic             tick_sel;
  logic             restart_hold;
  logic [CNT_W-1:0] last_val;
  int               ovf_exp;

  assign ovf_exp  = ovf_log2(BUS_EXP, LFO_EXP, cfg_q.bus_sel, cfg_q.code);
  assign last_val = CNT_W'((64'd1 << ovf_exp) - 64'd1);

  wdog_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (wdog_cfg_t'(cfg_wdata)),
    .cfg_q     (cfg_q)
  );

  wdog_tick_gate #(.RESTART_TICKS(RESTART_TICKS)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .lfo_tick     (lfo_tick),
    .bus_tick     (bus_tick),
    .bus_sel      (cfg_q.bus_sel),
    .stop_mode    (stop_mode),
    .tick_sel     (tick_sel),
    .restart_hold (restart_hold)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_q.en),
    .tick      (tick_sel),
    .hold      (restart_hold),
    .dbg_mode  (dbg_mode),
    .stop_mode (stop_mode),
    .svc_wr    (svc_wr),
    .last_val  (last_val),
    .wdog_rst  (wdog_rst)
  );

  p_req_needs_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |-> $past(tick_sel));

endmodule

// File: tb/wdog_top_test.sv
module wdog_top_test;

  localparam int BUS_EXP = 2;
  localparam int LFO_EXP = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lfo_tick = 1'b0;
  logic       bus_tick = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [4:0] cfg_wdata = 5'd0;
  logic       svc_wr = 1'b0;
  logic       dbg_mode = 1'b0;
  logic       stop_mode = 1'b0;
  logic       wdog_rst;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int cycles = 0;

  wdog_top #(.BUS_EXP(BUS_EXP), .LFO_EXP(LFO_EXP)) uut (
    .clk(clk), .rst_n(rst_n), .lfo_tick(lfo_tick), .bus_tick(bus_tick),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .svc_wr(svc_wr),
    .dbg_mode(dbg_mode), .stop_mode(stop_mode), .wdog_rst(wdog_rst)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (wdog_rst) pulses++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Expected timeout in ticks, restated from R3/R4.
  function automatic int want_ticks(input bit bus, input int code);
    int c;
    c = (code > 6) ? 6 : code;
    return bus ? (1 << BUS_EXP) * (1 << c) : (1 << LFO_EXP);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    lfo_tick = 0; bus_tick = 0; cfg_wr = 0; svc_wr = 0;
    dbg_mode = 0; stop_mode = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg_write(input bit en, input bit bus, input int code);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = {en, bus, 3'(code)};
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic give_ticks(input bit bus, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bus) bus_tick = 1'b1; else lfo_tick = 1'b1;
      @(negedge clk);
      bus_tick = 1'b0; lfo_tick = 1'b0;
    end
  endtask

  // Count ticks until the request appears; -1 if none within limit.
  // Also checks the request is gone one cycle later (R10).
  task automatic measure(input bit bus, input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (bus) bus_tick = 1'b1; else lfo_tick = 1'b1;
      @(negedge clk);
      bus_tick = 1'b0; lfo_tick = 1'b0;
      if (wdog_rst) begin
        n = i;
        @(negedge clk);
        check("R10 pulse width", int'(wdog_rst), 0);
        break;
      end
    end
  endtask

  initial begin
    int n;
    int p0;
    do_reset();
    check("R1 reset request low", int'(wdog_rst), 0);

    measure(1'b0, 100, n);
    check("R1 default timeout", n, want_ticks(1'b0, 7));
    measure(1'b0, 100, n);
    check("R10 full period after request", n, want_ticks(1'b0, 7));

    p0 = pulses;
    give_ticks(1'b1, 100);
    check("R11 bus ticks ignored under slow select", pulses - p0, 0);
    measure(1'b0, 100, n);
    check("R11 count untouched", n, want_ticks(1'b0, 7));

    // Sweep of source and code with lock check (R2, R3, R4).
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 8; c++) begin
        do_reset();
        cfg_write(1'b1, s[0], c);
        cfg_write(1'b0, ~s[0], c ^ 3);
        measure(s[0], 600, n);
        check(s ? "R3 bus timeout" : "R4 slow timeout", n, want_ticks(s[0], c));
        measure(s[0], 600, n);
        check("R2 later write ignored", n, want_ticks(s[0], c));
      end
    end

    // R2: first write equal to defaults still locks.
    do_reset();
    cfg_write(1'b1, 1'b0, 7);
    cfg_write(1'b1, 1'b1, 0);
    measure(1'b0, 100, n);
    check("R2 default write locks", n, want_ticks(1'b0, 7));

    // R9: disabled never requests.
    do_reset();
    cfg_write(1'b0, 1'b1, 0);
    p0 = pulses;
    give_ticks(1'b1, 300);
    give_ticks(1'b0, 300);
    check("R9 no request when disabled", pulses - p0, 0);

    // R5: service clears count, wins over a same-cycle tick.
    do_reset();
    cfg_write(1'b1, 1'b1, 0);
    give_ticks(1'b1, 3);
    @(negedge clk); svc_wr = 1'b1;
    @(negedge clk); svc_wr = 1'b0;
    measure(1'b1, 100, n);
    check("R5 service clears", n, want_ticks(1'b1, 0));
    give_ticks(1'b1, 3);
    p0 = pulses;
    @(negedge clk); svc_wr = 1'b1; bus_tick = 1'b1;
    @(negedge clk); svc_wr = 1'b0; bus_tick = 1'b0;
    @(negedge clk);
    check("R5 service beats tick", pulses - p0, 0);
    measure(1'b1, 100, n);
    check("R5 count restarted", n, want_ticks(1'b1, 0));

    // R6: debug freezes.
    do_reset();
    cfg_write(1'b1, 1'b1, 1);
    give_ticks(1'b1, 3);
    @(negedge clk); dbg_mode = 1'b1;
    p0 = pulses;
    give_ticks(1'b1, 20);
    check("R6 no request in debug", pulses - p0, 0);
    @(negedge clk); dbg_mode = 1'b0;
    measure(1'b1, 100, n);
    check("R6 resumes from held count", n, want_ticks(1'b1, 1) - 3);

    // R7 and R8: stop clears, exit delays by 3 ticks.
    do_reset();
    cfg_write(1'b1, 1'b1, 1);
    give_ticks(1'b1, 5);
    @(negedge clk); stop_mode = 1'b1;
    p0 = pulses;
    give_ticks(1'b1, 20);
    check("R7 no request in stop", pulses - p0, 0);
    @(negedge clk); stop_mode = 1'b0;
    measure(1'b1, 100, n);
    check("R8 restart delay then full count", n, 3 + want_ticks(1'b1, 1));

    // R8: other source does not use up the delay.
    do_reset();
    @(negedge clk); stop_mode = 1'b1;
    @(negedge clk); stop_mode = 1'b0;
    give_ticks(1'b1, 5);
    measure(1'b0, 100, n);
    check("R8 delay counts selected source only", n, 3 + want_ticks(1'b0, 7));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule